// File: doc/BRIEF.md
# HDLC Receive Deframer with Selectable CRC

This block takes the serial bit stream of one time-division channel and rebuilds HDLC frames as bytes for a downstream buffer. A bit counts only in a cycle where the channel's bit-enable strobe is high. In framed mode the block searches for the flag pattern and removes the zero a transmitter inserts after five ones in a row. It treats a run of seven ones as an abort. It packs the remaining bits into bytes, first received bit in bit 0, and checks the frame check sequence with either a 16-bit or a 32-bit CRC. A configuration input selects the CRC and may change between frames.

Every byte of a frame is delivered, including the FCS bytes. The first byte carries a start marker. The last byte carries an end marker and a good/bad verdict. For voice on a bearer channel, a transparent input turns off all framing. Each group of eight strobed bits then becomes one unmarked byte.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A frame is the bits between two flags (a zero, six ones, a zero). Its bytes come out on `out_valid` in order, first received bit in bit 0. The first byte has `out_sof`=1. The last byte, which is the final FCS byte, has `out_eof`=1.
- R2: Inside a frame, a zero that follows five consecutive ones is dropped and never reaches a byte.
- R3: With `crc32_sel`=0, the check uses the bit-reversed polynomial 0x8408, an all-ones preset and LSB-first bits over data plus FCS. `out_good`=1 on the last byte requires a residue of 0xF0B8.
- R4: With `crc32_sel`=1, the check uses the bit-reversed polynomial 0xEDB88320, an all-ones preset and LSB-first bits. `out_good`=1 requires a residue of 0xDEBB20E3.
- R5: A frame with fewer bytes than its FCS length plus one, or with a bit count that is not a multiple of eight, ends with `out_good`=0. A fragment that holds no complete byte produces no output.
- R6: Bits are taken only in cycles with `bit_en`=1. `out_valid` is high only in the cycle after a cycle with `bit_en`=1.
- R7: Seven consecutive ones abort the frame. If a byte is still pending, it comes out with `out_eof`=1 and `out_good`=0. All bits are then ignored until the next flag.
- R8: With `transparent`=1, every eight strobed bits form one byte with `out_sof`, `out_eof` and `out_good` all 0. Flags, ones runs and stuffed zeros get no special treatment.
- R9: Consecutive flags, whether separate or sharing a zero, produce no output.
- R10: After reset, no output is given, and bits arriving before the first flag are ignored.
- R11: A frame whose FCS does not match ends with `out_good`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Strobe marking a valid channel bit |
| bit_in | input | 1 | Serial channel bit |
| transparent | input | 1 | 1 = voice bypass, byte packing only |
| crc32_sel | input | 1 | 0 = 16-bit FCS, 1 = 32-bit FCS |
| out_valid | output | 1 | Byte strobe |
| out_data | output | 8 | Received byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_good | output | 1 | Frame passed length and FCS checks (with out_eof) |

## Verification
Every output is registered once, so a byte appears in the cycle right after the `bit_en` cycle that finishes it. The monitor samples on the falling edge and checks that the rising edge before it carried a strobe. In framed mode a byte is released only when the next byte completes, because a frame bit is held back seven positions until the line shows it is not part of a flag. The last byte appears one cycle after the final zero of the closing flag, or one cycle after the seventh one of an abort. The driver therefore pushes expected bytes before it sends a frame, and the monitor compares them in order whenever they arrive. Explicit idle checks after no-output cases confirm that nothing remains pending.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W      = 8;
    localparam int FLAG_ONES   = 6;
    localparam int STUFF_ONES  = 5;
    localparam int FCS16_BYTES = 2;
    localparam int FCS32_BYTES = 4;

    localparam logic [15:0] CRC16_POLY = 16'h8408;
    localparam logic [15:0] CRC16_GOOD = 16'hF0B8;
    localparam logic [31:0] CRC32_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC32_GOOD = 32'hDEBB20E3;

    typedef enum logic {ST_HUNT, ST_OPEN} rx_state_e;

    // one line event per strobed bit, at most one field set
    typedef struct packed {
        logic data;
        logic value;
        logic flag;
        logic abort;
    } bit_evt_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              sof;
        logic              eof;
        logic              good;
    } rx_out_t;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC16_POLY : 16'h0000);
    endfunction

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC32_POLY : 32'h0000_0000);
    endfunction

endpackage

// File: rtl/hdlc_rx_destuff.sv
module hdlc_rx_destuff
    import hdlc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     bit_en,
    input  logic     bit_in,
    output bit_evt_t evt
);
    localparam int RUN_W = $clog2(FLAG_ONES + 2);
    localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(FLAG_ONES);
    localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(STUFF_ONES);
    localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(FLAG_ONES + 1);

    logic [RUN_W-1:0] ones_q;

    always_comb begin
        evt = '0;
        if (bit_en && en) begin
            if (bit_in) begin
                if (ones_q == RUN_FLAG) begin
                    evt.abort = 1'b1;
                end else if (ones_q < RUN_FLAG) begin
                    evt.data  = 1'b1;
                    evt.value = 1'b1;
                end
            end else begin
                if (ones_q == RUN_FLAG) begin
                    evt.flag = 1'b1;
                end else if (ones_q < RUN_STUFF) begin
                    evt.data  = 1'b1;
                    evt.value = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ones_q <= '0;
        end else if (bit_en) begin
            if (!bit_in)
                ones_q <= '0;
            else if (ones_q != RUN_MAX)
                ones_q <= ones_q + 1'b1;
        end
    end

    a_r2_evt_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.data, evt.flag, evt.abort}));

    a_r6_run_holds: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && en) |=> $stable(ones_q));

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic bit_in,
    input  logic sel32,
    output logic match
);
    logic [31:0] c_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            c_q <= '1;
        end else if (step) begin
            if (sel32)
                c_q <= crc32_step(c_q, bit_in);
            else
                c_q <= {c_q[31:16], crc16_step(c_q[15:0], bit_in)};
        end
    end

    always_comb begin
        if (sel32)
            match = (c_q == CRC32_GOOD);
        else
            match = (c_q[15:0] == CRC16_GOOD);
    end

    a_r3_no_step_on_clear: assert property (@(posedge clk) disable iff (rst)
        !(clr && step));

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     transparent,
    input  logic     crc32_sel,
    input  logic     bit_en,
    input  logic     bit_in,
    input  bit_evt_t evt,
    input  logic     crc_match,
    output logic     crc_clr,
    output logic     crc_step,
    output logic     crc_bit,
    output rx_out_t  out_q
);
    localparam int DLY   = FLAG_ONES + 1;
    localparam int CNT_W = $clog2(DLY + 1);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] DLY_FULL = CNT_W'(DLY);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);
    localparam logic [LEN_W-1:0] MIN16    = LEN_W'(FCS16_BYTES + 1);
    localparam logic [LEN_W-1:0] MIN32    = LEN_W'(FCS32_BYTES + 1);

    rx_state_e         st_q;
    logic              mode_q;
    logic [DLY-1:0]    dly_q;
    logic [CNT_W-1:0]  dcnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BIT_W-1:0]  bcnt_q;
    logic [LEN_W-1:0]  nbytes_q;
    logic [BYTE_W-1:0] held_q;
    logic              held_vld_q;
    logic              first_q;

    logic              mode_chg, framed, hdlc_push, commit, shift_en;
    logic              frame_rst, byte_done, len_ok, cbit;
    logic [BYTE_W-1:0] sh_next;
    logic [LEN_W-1:0]  min_len;
    rx_out_t           out_n;

    always_comb begin
        mode_chg  = (transparent != mode_q);
        framed    = !mode_chg && !transparent;
        hdlc_push = framed && (st_q == ST_OPEN) && evt.data;
        commit    = hdlc_push && (dcnt_q == DLY_FULL);
        shift_en  = commit || (!mode_chg && transparent && bit_en);
        frame_rst = mode_chg || (framed && (evt.flag || evt.abort));
        cbit      = transparent ? bit_in : dly_q[0];
        sh_next   = {cbit, sh_q[BYTE_W-1:1]};
        byte_done = (bcnt_q == BIT_LAST);
        min_len   = crc32_sel ? MIN32 : MIN16;
        len_ok    = (bcnt_q == '0) && (nbytes_q >= min_len);

        crc_step  = commit;
        crc_bit   = dly_q[0];
        crc_clr   = mode_chg || transparent || (st_q == ST_HUNT) || evt.flag || evt.abort;

        out_n = '0;
        if (!mode_chg && transparent && bit_en && byte_done) begin
            out_n.valid = 1'b1;
            out_n.data  = sh_next;
        end else if (framed && (st_q == ST_OPEN) && held_vld_q) begin
            out_n.data = held_q;
            out_n.sof  = first_q;
            if (evt.flag) begin
                out_n.valid = 1'b1;
                out_n.eof   = 1'b1;
                out_n.good  = crc_match && len_ok;
            end else if (evt.abort) begin
                out_n.valid = 1'b1;
                out_n.eof   = 1'b1;
            end else if (commit && byte_done) begin
                out_n.valid = 1'b1;
            end
        end
        if (!out_n.valid)
            out_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_HUNT;
            mode_q     <= 1'b0;
            dly_q      <= '0;
            dcnt_q     <= '0;
            sh_q       <= '0;
            bcnt_q     <= '0;
            nbytes_q   <= '0;
            held_q     <= '0;
            held_vld_q <= 1'b0;
            first_q    <= 1'b1;
            out_q      <= '0;
        end else begin
            out_q  <= out_n;
            mode_q <= transparent;

            if (mode_chg)
                st_q <= ST_HUNT;
            else if (framed && evt.flag)
                st_q <= ST_OPEN;
            else if (framed && evt.abort)
                st_q <= ST_HUNT;

            if (frame_rst) begin
                dcnt_q <= '0;
            end else if (hdlc_push) begin
                dly_q <= {evt.value, dly_q[DLY-1:1]};
                if (dcnt_q != DLY_FULL)
                    dcnt_q <= dcnt_q + 1'b1;
            end

            if (frame_rst) begin
                bcnt_q     <= '0;
                nbytes_q   <= '0;
                held_vld_q <= 1'b0;
                first_q    <= 1'b1;
            end else if (shift_en) begin
                sh_q   <= sh_next;
                bcnt_q <= bcnt_q + 1'b1;
                if (byte_done && !transparent) begin
                    held_q     <= sh_next;
                    held_vld_q <= 1'b1;
                    if (nbytes_q != '1)
                        nbytes_q <= nbytes_q + 1'b1;
                    if (held_vld_q)
                        first_q <= 1'b0;
                end
            end
        end
    end

    a_r6_out_after_strobe: assert property (@(posedge clk) disable iff (rst)
        out_q.valid |-> $past(bit_en));

    a_r8_plain_bytes: assert property (@(posedge clk) disable iff (rst)
        (out_q.valid && $past(transparent)) |-> (!out_q.sof && !out_q.eof && !out_q.good));

    a_r7_abort_bad: assert property (@(posedge clk) disable iff (rst)
        (out_q.valid && $past(evt.abort)) |-> (out_q.eof && !out_q.good));

    a_r9_no_empty_frame: assert property (@(posedge clk) disable iff (rst)
        ($past(evt.flag) && $past(nbytes_q == '0)) |-> !out_q.valid);

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              transparent,
    input  logic              crc32_sel,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_good
);
    bit_evt_t evt;
    logic     crc_clr, crc_step, crc_bit, crc_match;
    rx_out_t  out_r;

    hdlc_rx_destuff u_destuff (
        .clk    (clk),
        .rst    (rst),
        .en     (!transparent),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .evt    (evt)
    );

    hdlc_rx_crc u_crc (
        .clk    (clk),
        .rst    (rst),
        .clr    (crc_clr),
        .step   (crc_step),
        .bit_in (crc_bit),
        .sel32  (crc32_sel),
        .match  (crc_match)
    );

    hdlc_rx_framer #(.LEN_W(4)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .transparent (transparent),
        .crc32_sel   (crc32_sel),
        .bit_en      (bit_en),
        .bit_in      (bit_in),
        .evt         (evt),
        .crc_match   (crc_match),
        .crc_clr     (crc_clr),
        .crc_step    (crc_step),
        .crc_bit     (crc_bit),
        .out_q       (out_r)
    );

    assign out_valid = out_r.valid;
    assign out_data  = out_r.data;
    assign out_sof   = out_r.sof;
    assign out_eof   = out_r.eof;
    assign out_good  = out_r.good;

endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       transparent = 1'b0;
    logic       crc32_sel = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sof, out_eof, out_good;

    int         n_checks = 0;
    int         n_fail = 0;
    int         gap_ctr = 0;
    int         run = 0;
    bit         done = 1'b0;
    logic       en_seen = 1'b0;
    string      cur_req = "R10";
    logic [10:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  frm[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_deframer u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .transparent(transparent), .crc32_sel(crc32_sel),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_good(out_good)
    );

    task automatic check(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    always @(posedge clk) en_seen <= bit_en;

    // monitor: compare each output byte with the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, $sformatf("unexpected byte actual=%h sof=%0b eof=%0b good=%0b expected=none",
                      out_data, out_sof, out_eof, out_good));
            end else begin
                logic [10:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(en_seen, "R6", "output without strobe in previous cycle actual=0 expected=1");
                check({out_data, out_sof, out_eof, out_good} == e, t,
                      $sformatf("actual=%h/%0b%0b%0b expected=%h/%0b%0b%0b",
                                out_data, out_sof, out_eof, out_good,
                                e[10:3], e[2], e[1], e[0]));
            end
        end
    end

    task automatic send_bit(input logic b);
        @(posedge clk); #1;
        bit_en = 1'b1; bit_in = b;
        @(posedge clk); #1;
        bit_en = 1'b0; bit_in = ~b;
        gap_ctr++;
        repeat (gap_ctr % 3) @(posedge clk);
    endtask

    task automatic send_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_flag();
        send_raw(8'h7E);
        run = 0;
    endtask

    task automatic send_stuffed(input logic b);
        send_bit(b);
        if (b) run++; else run = 0;
        if (run == 5) begin
            send_bit(1'b0);
            run = 0;
        end
    endtask

    task automatic push_exp(input logic [7:0] d, input bit s, input bit e, input bit g, input string req);
        exp_q.push_back({d, s, e, g});
        tag_q.push_back(req);
    endtask

    function automatic logic [31:0] bench_fcs(input bit use32);
        logic [31:0] c32;
        logic [15:0] c16;
        c32 = '1; c16 = '1;
        foreach (frm[k]) begin
            for (int i = 0; i < 8; i++) begin
                if (c32[0] ^ frm[k][i]) c32 = (c32 >> 1) ^ 32'hEDB88320; else c32 = c32 >> 1;
                if (c16[0] ^ frm[k][i]) c16 = (c16 >> 1) ^ 16'h8408;     else c16 = c16 >> 1;
            end
        end
        return use32 ? ~c32 : {16'h0, ~c16};
    endfunction

    task automatic send_frame(input bit use32, input bit add_fcs, input bit corrupt,
                              input int extra, input string req);
        logic [7:0]  all[$];
        logic [31:0] f;
        int          nb, minb;
        bit          good;
        all = frm;
        f = bench_fcs(use32);
        if (add_fcs) begin
            for (int i = 0; i < (use32 ? 4 : 2); i++) all.push_back(f[8*i +: 8]);
            if (corrupt) all[all.size()-1] = all[all.size()-1] ^ 8'h01;
        end
        nb   = all.size();
        minb = use32 ? 5 : 3;
        good = add_fcs && !corrupt && (extra == 0) && (nb >= minb);
        crc32_sel = use32;
        cur_req = req;
        for (int i = 0; i < nb; i++)
            push_exp(all[i], i == 0, i == nb - 1, (i == nb - 1) && good, req);
        send_flag();
        for (int i = 0; i < nb; i++)
            for (int j = 0; j < 8; j++) send_stuffed(all[i][j]);
        for (int i = 0; i < extra; i++) send_stuffed(i[0]);
        send_flag();
    endtask

    task automatic idle_check(input string req);
        repeat (30) @(posedge clk);
        check(exp_q.size() == 0, req,
              $sformatf("pending expected items actual=%0d expected=0", exp_q.size()));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", $sformatf("valid after reset actual=%0b expected=0", out_valid));

        // R10: bits before any flag are ignored
        cur_req = "R10";
        send_raw(8'hA5); send_raw(8'h3C); send_raw(8'h00);
        idle_check("R10");

        // R1 R2 R3: 16-bit FCS frame with stuffing-heavy bytes
        frm = '{8'h01, 8'h7E, 8'hFF, 8'h3E};
        send_frame(1'b0, 1'b1, 1'b0, 0, "R2");
        idle_check("R1");
        frm = '{8'hC0};
        send_frame(1'b0, 1'b1, 1'b0, 0, "R3");

        // R4: 32-bit FCS frame
        frm = '{8'hFF, 8'hFF, 8'h00, 8'hC3, 8'h5A};
        send_frame(1'b1, 1'b1, 1'b0, 0, "R4");
        frm = '{8'h3F};
        send_frame(1'b1, 1'b1, 1'b0, 0, "R4");

        // R11: corrupted FCS in both widths
        frm = '{8'h10, 8'h20, 8'h30};
        send_frame(1'b0, 1'b1, 1'b1, 0, "R11");
        send_frame(1'b1, 1'b1, 1'b1, 0, "R11");

        // R5: too short, odd bit count, fragment
        frm = '{8'h12, 8'h34};
        send_frame(1'b0, 1'b0, 1'b0, 0, "R5");
        frm = '{8'h9A, 8'hBC, 8'hDE, 8'hF0};
        send_frame(1'b1, 1'b0, 1'b0, 0, "R5");
        frm = '{8'h55, 8'h66};
        send_frame(1'b0, 1'b1, 1'b0, 3, "R5");
        cur_req = "R5";
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        idle_check("R5");

        // R7: abort mid-frame, then junk that must be ignored
        crc32_sel = 1'b0;
        cur_req = "R7";
        push_exp(8'h11, 1'b1, 1'b0, 1'b0, "R7");
        push_exp(8'h22, 1'b0, 1'b1, 1'b0, "R7");
        send_flag();
        send_raw(8'h11); send_raw(8'h22); send_raw(8'h44);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_raw(8'h00); send_raw(8'h00);
        idle_check("R7");
        frm = '{8'hA1, 8'hB2};
        send_frame(1'b0, 1'b1, 1'b0, 0, "R7");

        // R9: back-to-back flags, separate and sharing a zero
        cur_req = "R9";
        send_flag(); send_flag(); send_flag();
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        idle_check("R9");

        // R8: transparent bytes pass unmodified
        repeat (3) @(posedge clk);
        #1 transparent = 1'b1;
        repeat (3) @(posedge clk);
        cur_req = "R8";
        push_exp(8'h7E, 1'b0, 1'b0, 1'b0, "R8");
        push_exp(8'hFF, 1'b0, 1'b0, 1'b0, "R8");
        push_exp(8'hFF, 1'b0, 1'b0, 1'b0, "R8");
        push_exp(8'h1F, 1'b0, 1'b0, 1'b0, "R8");
        send_raw(8'h7E); send_raw(8'hFF); send_raw(8'hFF); send_raw(8'h1F);
        idle_check("R8");
        #1 transparent = 1'b0;
        repeat (3) @(posedge clk);
        frm = '{8'h42, 8'h24, 8'h81};
        send_frame(1'b0, 1'b1, 1'b0, 0, "R1");

        idle_check("R1");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R6: watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule